// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It owns the clock-enable pin and the command/address bus from reset until the memory is ready for use. It holds clock-enable low while the clock settles. It then raises clock-enable and steps through the mandatory bring-up commands: precharge-all, extended-mode write with the DLL enabled, mode write with DLL reset, a second precharge-all, a programmable number of auto-refreshes, and a final mode write with the DLL-reset bit cleared. When the last mode write has settled and the DLL lock window has elapsed, it raises `init_done_o` and leaves the bus idle for normal traffic.

All waits are parameters counted in clock cycles. The stable-clock wait is derived from the clock frequency in MHz and the settle time in microseconds. The operating-mode and extended-mode values are taken from input ports at the moment each write is issued. A restart input reruns the whole sequence, DLL reset included, so the device can be brought up again after the clock frequency changes. The relative order of the DLL-reset write and the second precharge-all is chosen by a parameter.

Top module: `ddr_init_seq`

## Requirements
- R1: On the reset edge, `cke_o` is low, `cmd_o` is NOP (3'b111), `bank_o` and `addr_o` are zero, and `init_done_o` is low. These values hold for STABLE_CYC = CLK_MHZ*STABLE_US cycles. `cke_o` rises exactly STABLE_CYC cycles after the reset edge. While `cke_o` is low, only NOP appears.
- R2: One cycle after `cke_o` rises, a precharge-all is issued: `cmd_o`=3'b010, `addr_o` bit 10 set, all other address bits and the bank zero.
- R3: T_RP cycles after the first precharge-all, an extended-mode write is issued. `cmd_o` is 3'b000 and `bank_o` is 2'b01. `addr_o` equals `ext_word_i` with bit 0 (DLL disable) forced to 0.
- R4: The DLL-reset mode write has `cmd_o`=3'b000, `bank_o`=2'b00, and `addr_o` equal to `mode_word_i` with bit 8 forced to 1. With DLLRST_FIRST=1 it follows the extended write, and the second precharge-all comes after it. With DLLRST_FIRST=0 the two swap places. The next command comes T_MRD cycles after a mode or extended write and T_RP cycles after a precharge.
- R5: Exactly REFRESH_COUNT auto-refreshes are issued after the DLL-reset write and the second precharge-all. Each has `cmd_o`=3'b001 with bank and address zero, and consecutive refreshes are T_RFC cycles apart.
- R6: T_RFC cycles after the last refresh, the final mode write is issued: `cmd_o`=3'b000, `bank_o`=2'b00, and `addr_o` equal to `mode_word_i` with bit 8 forced to 0.
- R7: `init_done_o` rises at the later of two points: T_MRD cycles after the final mode write, or DLL_LOCK cycles after the DLL-reset write. Once high it stays high, and the bus shows only NOP, until reset or restart.
- R8: A high `restart_i` sampled at an edge drives `cke_o` and `init_done_o` low and the bus to NOP on that edge. The complete sequence of R1 to R7 is then rerun, timed from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_i | input | 1 | Rerun the whole bring-up sequence |
| mode_word_i | input | 12 | Operating-mode value for the mode register |
| ext_word_i | input | 12 | Value for the extended-mode register |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_o | output | 3 | Command as {row strobe, column strobe, write enable}, all active low |
| bank_o | output | 2 | Bank select; 2'b01 selects the extended register |
| addr_o | output | 12 | Address bus carrying register values and the precharge-all bit |
| init_done_o | output | 1 | Bring-up finished; bus handed to normal traffic |

## Verification
The hardest situation to reach is a restart that lands in the middle of the command phase or inside the DLL lock window. In that case the timers, the refresh count and the lock window must all be discarded, and nothing from the aborted run may leak into the new one. The stimulus issues restarts followed by a random delay that spans the clock-settle wait, the command burst and the lock wait. It then issues a second restart and compares the full command trace of the final run against the expected schedule. A second instance runs with the swapped order, three refreshes and a short lock window, so that the done point is set by the last mode write rather than by the DLL lock.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    localparam int unsigned ADDR_W      = 12;
    localparam int unsigned BANK_W      = 2;
    localparam int unsigned AP_BIT      = 10;
    localparam int unsigned DLL_RST_BIT = 8;
    localparam int unsigned DLL_DIS_BIT = 0;

    // {row strobe, column strobe, write enable}, active low, chip select held low
    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_NOP = 3'b111
    } ddr_cmd_e;

    typedef enum logic [3:0] {
        ST_HOLD,
        ST_PRE1,
        ST_EMRS,
        ST_DLLRST,
        ST_PRE2,
        ST_REFRESH,
        ST_MODE,
        ST_FINISH,
        ST_DONE
    } init_step_e;

    typedef struct packed {
        ddr_cmd_e            cmd;
        logic [BANK_W-1:0]   bank;
        logic [ADDR_W-1:0]   addr;
    } ddr_bus_t;

    localparam ddr_bus_t BUS_IDLE = '{cmd: CMD_NOP, bank: '0, addr: '0};

    function automatic logic is_cmd_step(input init_step_e s);
        return s inside {ST_PRE1, ST_EMRS, ST_DLLRST, ST_PRE2, ST_REFRESH, ST_MODE};
    endfunction

    function automatic init_step_e step_after(input init_step_e s,
                                              input logic dllrst_first,
                                              input logic last_ref);
        case (s)
            ST_HOLD:    return ST_PRE1;
            ST_PRE1:    return ST_EMRS;
            ST_EMRS:    return dllrst_first ? ST_DLLRST : ST_PRE2;
            ST_DLLRST:  return dllrst_first ? ST_PRE2 : ST_REFRESH;
            ST_PRE2:    return dllrst_first ? ST_REFRESH : ST_DLLRST;
            ST_REFRESH: return last_ref ? ST_MODE : ST_REFRESH;
            ST_MODE:    return ST_FINISH;
            default:    return s;
        endcase
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int unsigned W         = 8,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= RESET_VAL;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign expired_o = (cnt_q == '0);

    // R4: command spacing relies on a strict one-per-cycle countdown
    assert_count_down_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
(
    input  init_step_e         step_i,
    input  logic               fire_i,
    input  logic [ADDR_W-1:0]  mode_word_i,
    input  logic [ADDR_W-1:0]  ext_word_i,
    output ddr_bus_t           bus_o
);

    always_comb begin
        bus_o = BUS_IDLE;
        if (fire_i) begin
            case (step_i)
                ST_PRE1, ST_PRE2: begin
                    bus_o.cmd          = CMD_PRE;
                    bus_o.addr[AP_BIT] = 1'b1;
                end
                ST_EMRS: begin
                    bus_o.cmd               = CMD_MRS;
                    bus_o.bank              = BANK_W'(1);
                    bus_o.addr              = ext_word_i;
                    bus_o.addr[DLL_DIS_BIT] = 1'b0;
                end
                ST_DLLRST: begin
                    bus_o.cmd               = CMD_MRS;
                    bus_o.addr              = mode_word_i;
                    bus_o.addr[DLL_RST_BIT] = 1'b1;
                end
                ST_REFRESH: bus_o.cmd = CMD_REF;
                ST_MODE: begin
                    bus_o.cmd               = CMD_MRS;
                    bus_o.addr              = mode_word_i;
                    bus_o.addr[DLL_RST_BIT] = 1'b0;
                end
                default: bus_o = BUS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 100,
    parameter int unsigned STABLE_US     = 200,
    parameter int unsigned T_RP          = 5,
    parameter int unsigned T_MRD         = 2,
    parameter int unsigned T_RFC         = 19,
    parameter int unsigned DLL_LOCK      = 200,
    parameter int unsigned REFRESH_COUNT = 2,
    parameter bit          DLLRST_FIRST  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    input  logic [ADDR_W-1:0] mode_word_i,
    input  logic [ADDR_W-1:0] ext_word_i,
    output logic              cke_o,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              init_done_o
);

    localparam int unsigned STABLE_CYC = CLK_MHZ * STABLE_US;
    localparam int unsigned MAX_WAIT   = max_u(max_u(STABLE_CYC, T_RFC), max_u(T_RP, T_MRD));
    localparam int unsigned WAIT_W     = $clog2(MAX_WAIT + 1);
    localparam int unsigned LOCK_W     = $clog2(DLL_LOCK + 1);
    localparam int unsigned REF_W      = $clog2(REFRESH_COUNT + 1);

    init_step_e         step_q;
    logic               cke_q, done_q;
    logic [REF_W-1:0]   ref_left_q;
    ddr_bus_t           bus_q, enc_bus;

    logic               wait_exp, lock_exp;
    logic               fire, hold_exit, wait_load, lock_load;
    logic [WAIT_W-1:0]  wait_val;
    int unsigned        gap;

    always_comb begin
        fire      = is_cmd_step(step_q) && wait_exp;
        hold_exit = (step_q == ST_HOLD) && wait_exp;
        case (step_q)
            ST_PRE1, ST_PRE2: gap = T_RP;
            ST_REFRESH:       gap = T_RFC;
            default:          gap = T_MRD;
        endcase
        wait_load = restart_i || fire || hold_exit;
        if (restart_i)      wait_val = WAIT_W'(STABLE_CYC - 1);
        else if (hold_exit) wait_val = '0;
        else                wait_val = WAIT_W'(gap - 1);
        lock_load = restart_i || (fire && step_q == ST_DLLRST);
    end

    ddr_init_timer #(.W(WAIT_W), .RESET_VAL(WAIT_W'(STABLE_CYC - 1))) u_wait (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wait_load),
        .load_val_i (wait_val),
        .expired_o  (wait_exp)
    );

    ddr_init_timer #(.W(LOCK_W), .RESET_VAL(LOCK_W'(DLL_LOCK - 1))) u_lock (
        .clk        (clk),
        .rst        (rst),
        .load_i     (lock_load),
        .load_val_i (LOCK_W'(DLL_LOCK - 1)),
        .expired_o  (lock_exp)
    );

    ddr_init_cmd_enc u_enc (
        .step_i      (step_q),
        .fire_i      (fire),
        .mode_word_i (mode_word_i),
        .ext_word_i  (ext_word_i),
        .bus_o       (enc_bus)
    );

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            step_q     <= ST_HOLD;
            cke_q      <= 1'b0;
            done_q     <= 1'b0;
            ref_left_q <= REF_W'(REFRESH_COUNT);
            bus_q      <= BUS_IDLE;
        end else begin
            bus_q <= enc_bus;
            if (hold_exit) begin
                cke_q  <= 1'b1;
                step_q <= ST_PRE1;
            end else if (fire) begin
                step_q <= step_after(step_q, DLLRST_FIRST, ref_left_q == REF_W'(1));
                if (step_q == ST_REFRESH)
                    ref_left_q <= ref_left_q - REF_W'(1);
            end else if (step_q == ST_FINISH && wait_exp && lock_exp) begin
                done_q <= 1'b1;
                step_q <= ST_DONE;
            end
        end
    end

    assign cke_o       = cke_q;
    assign cmd_o       = bus_q.cmd;
    assign bank_o      = bus_q.bank;
    assign addr_o      = bus_q.addr;
    assign init_done_o = done_q;

    assert_cke_gates_cmd_R1: assert property (@(posedge clk) disable iff (rst)
        !cke_o |-> (cmd_o == CMD_NOP));

    assert_wake_precharge_R2: assert property (@(posedge clk) disable iff (rst || restart_i)
        $rose(cke_o) |=> (cmd_o == CMD_PRE) && addr_o[AP_BIT]);

    assert_done_after_lock_R7: assert property (@(posedge clk) disable iff (rst)
        init_done_o |-> lock_exp);

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst || restart_i)
        init_done_o |=> init_done_o);

    assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (rst)
        init_done_o |-> (cmd_o == CMD_NOP));

    assert_restart_clears_R8: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (!cke_o && !init_done_o && cmd_o == CMD_NOP));

endmodule

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int STABLE     = 400;   // CLK_MHZ=2, STABLE_US=200
    localparam int TRP        = 5;
    localparam int TMRD       = 2;
    localparam int TRFC       = 19;
    localparam int RUN_SPAN   = 700;
    localparam int K_CKE      = 8;
    localparam int K_DONE     = 9;
    localparam int K_FALL     = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst, restart;
    logic [11:0] mode_w, ext_w;
    logic        cke_w  [2];
    logic [2:0]  cmd_w  [2];
    logic [1:0]  bank_w [2];
    logic [11:0] addr_w [2];
    logic        done_w [2];

    ddr_init_seq #(.CLK_MHZ(2), .STABLE_US(200), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
                   .DLL_LOCK(200), .REFRESH_COUNT(2), .DLLRST_FIRST(1'b1)) uut (
        .clk(clk), .rst(rst), .restart_i(restart), .mode_word_i(mode_w), .ext_word_i(ext_w),
        .cke_o(cke_w[0]), .cmd_o(cmd_w[0]), .bank_o(bank_w[0]), .addr_o(addr_w[0]),
        .init_done_o(done_w[0]));

    ddr_init_seq #(.CLK_MHZ(2), .STABLE_US(200), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
                   .DLL_LOCK(40), .REFRESH_COUNT(3), .DLLRST_FIRST(1'b0)) uut_alt (
        .clk(clk), .rst(rst), .restart_i(restart), .mode_word_i(mode_w), .ext_word_i(ext_w),
        .cke_o(cke_w[1]), .cmd_o(cmd_w[1]), .bank_o(bank_w[1]), .addr_o(addr_w[1]),
        .init_done_o(done_w[1]));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int vectors = 0;
    int fails   = 0;

    // event log written only by the monitor
    int   ev_n    [2] = '{0, 0};
    int   ev_kind [2][512];
    int   ev_t    [2][512];
    int   ev_bank [2][512];
    int   ev_addr [2][512];
    logic cke_prev  [2] = '{1'b0, 1'b0};
    logic done_prev [2] = '{1'b0, 1'b0};

    task automatic log_ev(input int i, input int k, input int b, input int a);
        if (ev_n[i] < 512) begin
            ev_kind[i][ev_n[i]] = k;
            ev_t[i][ev_n[i]]    = cyc;
            ev_bank[i][ev_n[i]] = b;
            ev_addr[i][ev_n[i]] = a;
            ev_n[i]++;
        end
    endtask

    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst) begin
                if (cke_w[i] && !cke_prev[i]) log_ev(i, K_CKE, 0, 0);
                if (!cke_w[i] && cke_prev[i]) log_ev(i, K_FALL, 0, 0);
                if (cmd_w[i] != 3'b111) log_ev(i, int'(cmd_w[i]), int'(bank_w[i]), int'(addr_w[i]));
                if (done_w[i] && !done_prev[i]) log_ev(i, K_DONE, 0, 0);
                if (!done_w[i] && done_prev[i]) log_ev(i, K_FALL, 0, 0);
            end
            cke_prev[i]  = cke_w[i];
            done_prev[i] = done_w[i];
        end
    end

    // expected schedule
    int    exp_n    [2];
    int    exp_kind [2][24];
    int    exp_t    [2][24];
    int    exp_bank [2][24];
    int    exp_addr [2][24];
    string exp_req  [2][24];
    int    base     [2];

    task automatic push(input int i, input int k, input int t, input int b, input int a, input string r);
        exp_kind[i][exp_n[i]] = k;
        exp_t[i][exp_n[i]]    = t;
        exp_bank[i][exp_n[i]] = b;
        exp_addr[i][exp_n[i]] = a;
        exp_req[i][exp_n[i]]  = r;
        exp_n[i]++;
    endtask

    task automatic build(input int i, input int start, input logic [11:0] mw, input logic [11:0] ew);
        int lock, nref, t, trst, tdone;
        bit first;
        lock  = (i == 0) ? 200 : 40;
        nref  = (i == 0) ? 2 : 3;
        first = (i == 0);
        exp_n[i] = 0;
        t = start + STABLE;
        push(i, K_CKE, t, 0, 0, "R1");
        t += 1;
        push(i, 2, t, 0, 1 << 10, "R2");
        t += TRP;
        push(i, 0, t, 1, int'(ew & 12'hFFE), "R3");
        t += TMRD;
        if (first) begin
            push(i, 0, t, 0, int'(mw | 12'h100), "R4");
            trst = t;
            t += TMRD;
            push(i, 2, t, 0, 1 << 10, "R4");
            t += TRP;
        end else begin
            push(i, 2, t, 0, 1 << 10, "R4");
            t += TRP;
            push(i, 0, t, 0, int'(mw | 12'h100), "R4");
            trst = t;
            t += TMRD;
        end
        for (int r = 0; r < nref; r++) begin
            push(i, 1, t, 0, 0, "R5");
            t += TRFC;
        end
        push(i, 0, t, 0, int'(mw & 12'hEFF), "R6");
        t += TMRD;
        tdone = (t > trst + lock) ? t : trst + lock;
        push(i, K_DONE, tdone, 0, 0, "R7");
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int expv);
        vectors++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic compare(input int i);
        int k = 0;
        for (int j = base[i]; j < ev_n[i]; j++) begin
            if (ev_kind[i][j] < K_FALL) begin
                if (k < exp_n[i]) begin
                    chk_eq(exp_req[i][k], $sformatf("inst%0d ev%0d kind", i, k), ev_kind[i][j], exp_kind[i][k]);
                    chk_eq(exp_req[i][k], $sformatf("inst%0d ev%0d cycle", i, k), ev_t[i][j], exp_t[i][k]);
                    chk_eq(exp_req[i][k], $sformatf("inst%0d ev%0d bank", i, k), ev_bank[i][j], exp_bank[i][k]);
                    chk_eq(exp_req[i][k], $sformatf("inst%0d ev%0d addr", i, k), ev_addr[i][j], exp_addr[i][k]);
                end
                k++;
            end
        end
        chk_eq("R7", $sformatf("inst%0d event count", i), k, exp_n[i]);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
        #1;
    endtask

    task automatic check_idle_done(input string tag);
        for (int i = 0; i < 2; i++) begin
            chk_eq("R7", {tag, " done held"}, int'(done_w[i]), 1);
            chk_eq("R7", {tag, " bus idle"}, int'(cmd_w[i]), 7);
        end
    endtask

    task automatic do_restart(input logic [11:0] mw, input logic [11:0] ew, output int start);
        @(negedge clk);
        #1;
        restart = 1'b1;
        mode_w  = mw;
        ext_w   = ew;
        start   = cyc + 1;
        @(negedge clk);
        #1;
        restart = 1'b0;
        for (int i = 0; i < 2; i++) begin
            chk_eq("R8", $sformatf("inst%0d cke after restart", i), int'(cke_w[i]), 0);
            chk_eq("R8", $sformatf("inst%0d done after restart", i), int'(done_w[i]), 0);
            chk_eq("R8", $sformatf("inst%0d cmd after restart", i), int'(cmd_w[i]), 7);
            base[i] = ev_n[i];
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog expired: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int start;
        logic [11:0] mw, ew;
        void'($urandom(32'h5EED));
        rst     = 1'b1;
        restart = 1'b0;
        mode_w  = 12'h233;
        ext_w   = 12'h001;
        repeat (4) @(negedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
            chk_eq("R1", "reset cke", int'(cke_w[i]), 0);
            chk_eq("R1", "reset cmd", int'(cmd_w[i]), 7);
            chk_eq("R1", "reset bank", int'(bank_w[i]), 0);
            chk_eq("R1", "reset addr", int'(addr_w[i]), 0);
            chk_eq("R1", "reset done", int'(done_w[i]), 0);
        end
        start = cyc;      // last edge that saw reset high
        rst   = 1'b0;
        for (int i = 0; i < 2; i++) begin
            base[i] = ev_n[i];
            build(i, start, mode_w, ext_w);
        end
        wait_until(start + RUN_SPAN);
        compare(0);
        compare(1);
        check_idle_done("after reset run");

        for (int r = 1; r <= 7; r++) begin
            if (r == 1)      begin mw = 12'hFFF; ew = 12'hFFF; end
            else if (r == 2) begin mw = 12'h000; ew = 12'h000; end
            else             begin mw = 12'($urandom); ew = 12'($urandom); end
            if (r % 2 == 0) begin
                // R8: abort a run at a random point, then start over
                do_restart(12'($urandom), 12'($urandom), start);
                repeat ($urandom_range(5, 620)) @(negedge clk);
            end
            do_restart(mw, ew, start);
            for (int i = 0; i < 2; i++) build(i, start, mw, ew);
            wait_until(start + RUN_SPAN);
            compare(0);
            compare(1);
            check_idle_done($sformatf("run %0d", r));
        end

        summary();
        $finish;
    end

endmodule